// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block sits beside the receive and transmit FIFOs of a UART and turns their fill levels into interrupt information. Each cycle it derives a live status word from the two FIFO counts and two programmable trigger levels: trigger reached, empty and full for each direction. The UART datapath also supplies one-cycle event pulses for overrun, framing error, parity error, receive timeout, modem-status change and transmit overflow.

Selected live conditions and all event pulses are captured in a sticky interrupt register, where they stay until software clears them by writing ones. A mask register gates the sticky bits onto a single level-sensitive interrupt line. Software can only change the mask through a set port and a clear port. A small register port gives access to the mask, the sticky register, the live status word and the two trigger levels. The FIFOs, the shifters and the baud timing are outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word, read at address 4, has these bits: bit 0 is set when rx_count >= receive trigger, bit 1 when rx_count == 0, bit 2 when rx_count == DEPTH (default 64), bit 3 when tx_count == 0 and bit 4 when tx_count == DEPTH. It follows the count inputs in the same cycle. All other bits are zero except bit 13 (R2).
- R2: The live status word sets bit 13 when tx_count >= transmit trigger. On each clock edge this condition is latched into bit 10 of the sticky register, not into bit 13.
- R3: On every clock edge, live status bits 0 to 4 are ORed into sticky bits 0 to 4. A sticky bit, once set, stays set until it is cleared by a write (R5).
- R4: Event pulses set these sticky bits at the next clock edge: receive overrun bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem status bit 9, transmit overflow bit 12.
- R5: The sticky register is read at address 3. A write to address 3 clears each sticky bit that is 1 in the write data. If a set condition for the same bit is present in the same cycle, the bit stays set.
- R6: The mask is read at address 2. A write to address 0 ORs data bits 12:0 into the mask. A write to address 1 clears the mask bits that are 1 in the data. A write to address 2 leaves the mask unchanged.
- R7: irq is high exactly when some bit of (mask AND sticky) is 1, as those registers stand after the most recent clock edge.
- R8: While reset is held, and after it is released, the mask and sticky registers are zero, both trigger levels are 32, and irq is low.
- R9: The receive trigger level is read and written at address 5 and the transmit trigger level at address 6, using data bits 6:0. A write to address 4 has no effect. Reads of addresses 0, 1 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_count | input | 7 | Receive FIFO fill level |
| tx_count | input | 7 | Transmit FIFO fill level |
| evt_rx_overrun | input | 1 | Receive overrun pulse |
| evt_frame_err | input | 1 | Framing error pulse |
| evt_parity_err | input | 1 | Parity error pulse |
| evt_rx_timeout | input | 1 | Receive timeout pulse |
| evt_modem | input | 1 | Modem status change pulse |
| evt_tx_overflow | input | 1 | Transmit overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a clear that arrives in the same cycle as a fresh set of the same bit. If the set did not win, that event would be lost. Live conditions such as "receive FIFO empty" set their bit again on every edge, so the stimulus has to keep the count at the condition while it writes the clear, and then move the count away before a second clear can take effect. Directed sequences build exactly this case for a level bit and for an event pulse. Random traffic then mixes counts placed on the trigger, depth and empty boundaries with clears, enables and disables on random cycles.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int DW = 16;
  localparam int SW = 13;

  localparam int RAW_RXTRIG  = 0;
  localparam int RAW_RXEMPTY = 1;
  localparam int RAW_RXFULL  = 2;
  localparam int RAW_TXEMPTY = 3;
  localparam int RAW_TXFULL  = 4;
  localparam int RAW_TXTRIG  = 13;

  localparam int IS_TXTRIG   = 10;
  localparam int IS_RXOVR    = 5;
  localparam int IS_FRAME    = 6;
  localparam int IS_PARITY   = 7;
  localparam int IS_TIMEOUT  = 8;
  localparam int IS_MODEM    = 9;
  localparam int IS_TXOVF    = 12;

  typedef enum logic [2:0] {
    A_MASK_SET = 3'd0,
    A_MASK_CLR = 3'd1,
    A_MASK     = 3'd2,
    A_STICKY   = 3'd3,
    A_LIVE     = 3'd4,
    A_RXTRG    = 3'd5,
    A_TXTRG    = 3'd6,
    A_NONE     = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic tx_ovf;
    logic modem;
    logic timeout;
    logic parity;
    logic frame;
    logic rx_ovr;
  } evt_t;
endpackage

// File: rtl/uirq_status.sv
module uirq_status
  import uirq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_trig,
  input  logic [CW-1:0] tx_trig,
  output logic [DW-1:0] live
);
  localparam int NDIR = 2;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt  [NDIR];
  logic [CW-1:0] trig [NDIR];
  logic [NDIR-1:0] at_trig, is_empty, is_full;

  assign cnt[0]  = rx_cnt;
  assign cnt[1]  = tx_cnt;
  assign trig[0] = rx_trig;
  assign trig[1] = tx_trig;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign at_trig[d]  = (cnt[d] >= trig[d]);
    assign is_empty[d] = (cnt[d] == '0);
    assign is_full[d]  = (cnt[d] == FULL_CNT);
  end

  always_comb begin
    live              = '0;
    live[RAW_RXTRIG]  = at_trig[0];
    live[RAW_RXEMPTY] = is_empty[0];
    live[RAW_RXFULL]  = is_full[0];
    live[RAW_TXEMPTY] = is_empty[1];
    live[RAW_TXFULL]  = is_full[1];
    live[RAW_TXTRIG]  = at_trig[1];
  end
endmodule

// File: rtl/uirq_trig.sv
module uirq_trig #(
  parameter int CW         = 7,
  parameter int TRIG_RESET = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rx_trig,
  output logic [CW-1:0] tx_trig
);
  localparam logic [CW-1:0] RST_VAL = CW'(TRIG_RESET);

  logic [CW-1:0] lvl_q [2];
  logic [CW-1:0] lvl_d [2];

  for (genvar i = 0; i < 2; i++) begin : g_lvl
    always_comb begin
      lvl_d[i] = lvl_q[i];
      if (we[i]) lvl_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= RST_VAL;
      else        lvl_q[i] <= lvl_d[i];
    end
  end

  assign rx_trig = lvl_q[0];
  assign tx_trig = lvl_q[1];

  a_r9_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(we[0])) |-> (lvl_q[0] == $past(lvl_q[0])));
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask
  import uirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] mask
);
  logic [SW-1:0] mask_d;

  always_comb begin
    mask_d = mask;
    if (set_we) mask_d = mask_d | wdata;
    if (clr_we) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_d;
  end

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr_we)) |-> ((mask & $past(wdata)) == '0));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(set_we) && !$past(clr_we)) |-> $stable(mask));
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky
  import uirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_data,
  output logic [SW-1:0] sticky
);
  logic [SW-1:0] keep;
  logic [SW-1:0] sticky_d;

  always_comb begin
    keep     = clr_we ? (sticky & ~clr_data) : sticky;
    sticky_d = keep | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= sticky_d;
  end

  a_r3_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr_we)) |-> ((sticky & $past(sticky)) == $past(sticky)));

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sticky & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int TRIG_RESET = 32,
  parameter int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          evt_rx_overrun,
  input  logic          evt_frame_err,
  input  logic          evt_parity_err,
  input  logic          evt_rx_timeout,
  input  logic          evt_modem,
  input  logic          evt_tx_overflow,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr);

  logic we_mset, we_mclr, we_clr;
  logic [1:0] we_trig;
  always_comb begin
    we_mset    = reg_wr && (addr == A_MASK_SET);
    we_mclr    = reg_wr && (addr == A_MASK_CLR);
    we_clr     = reg_wr && (addr == A_STICKY);
    we_trig[0] = reg_wr && (addr == A_RXTRG);
    we_trig[1] = reg_wr && (addr == A_TXTRG);
  end

  logic [CW-1:0] rx_trig, tx_trig;
  logic [DW-1:0] live;
  logic [SW-1:0] mask, sticky, set_vec;
  evt_t          evt;

  uirq_trig #(.CW(CW), .TRIG_RESET(TRIG_RESET)) u_trig (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (we_trig),
    .wdata   (reg_wdata[CW-1:0]),
    .rx_trig (rx_trig),
    .tx_trig (tx_trig)
  );

  uirq_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
    .rx_cnt  (rx_count),
    .tx_cnt  (tx_count),
    .rx_trig (rx_trig),
    .tx_trig (tx_trig),
    .live    (live)
  );

  assign evt = '{tx_ovf: evt_tx_overflow, modem: evt_modem, timeout: evt_rx_timeout,
                 parity: evt_parity_err, frame: evt_frame_err, rx_ovr: evt_rx_overrun};

  always_comb begin
    set_vec             = '0;
    set_vec[4:0]        = live[4:0];
    set_vec[IS_TXTRIG]  = live[RAW_TXTRIG];
    set_vec[IS_RXOVR]   = evt.rx_ovr;
    set_vec[IS_FRAME]   = evt.frame;
    set_vec[IS_PARITY]  = evt.parity;
    set_vec[IS_TIMEOUT] = evt.timeout;
    set_vec[IS_MODEM]   = evt.modem;
    set_vec[IS_TXOVF]   = evt.tx_ovf;
  end

  uirq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_we (we_mset),
    .clr_we (we_mclr),
    .wdata  (reg_wdata[SW-1:0]),
    .mask   (mask)
  );

  uirq_sticky u_sticky (
    .clk      (clk),
    .rst_n    (rst_q),
    .set_vec  (set_vec),
    .clr_we   (we_clr),
    .clr_data (reg_wdata[SW-1:0]),
    .sticky   (sticky)
  );

  assign irq = |(mask & sticky);

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      A_MASK:   reg_rdata[SW-1:0] = mask;
      A_STICKY: reg_rdata[SW-1:0] = sticky;
      A_LIVE:   reg_rdata         = live;
      A_RXTRG:  reg_rdata[CW-1:0] = rx_trig;
      A_TXTRG:  reg_rdata[CW-1:0] = tx_trig;
      default:  reg_rdata         = '0;
    endcase
  end

  a_r7_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && ($past(mask) == '0) && !$past(we_mset)) |-> !irq);

  a_r2_txtrig_latched: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(live[RAW_TXTRIG])) |-> sticky[IS_TXTRIG]);

  a_r8_quiet_in_reset: assert property (@(posedge clk)
    !rst_q |-> (!irq && (mask == '0) && (sticky == '0)));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic e_ovr = 0, e_frm = 0, e_par = 0, e_to = 0, e_mod = 0, e_tov = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  uart_irq_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .evt_rx_overrun(e_ovr), .evt_frame_err(e_frm), .evt_parity_err(e_par),
    .evt_rx_timeout(e_to), .evt_modem(e_mod), .evt_tx_overflow(e_tov),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [12:0] m_mask, m_stk;
  logic [6:0]  m_rt, m_tt;
  bit done = 0;

  function automatic logic [15:0] f_live(logic [6:0] rc, logic [6:0] tc, logic [6:0] rt, logic [6:0] tt);
    logic [15:0] r = '0;
    r[0] = rc >= rt; r[1] = rc == 0; r[2] = rc == DEPTH;
    r[3] = tc == 0;  r[4] = tc == DEPTH; r[13] = tc >= tt;
    return r;
  endfunction

  function automatic logic [12:0] f_set(logic [15:0] lv, logic [5:0] ev);
    logic [12:0] s = '0;
    s[4:0] = lv[4:0]; s[10] = lv[13];
    s[5] = ev[0]; s[6] = ev[1]; s[7] = ev[2]; s[8] = ev[3]; s[9] = ev[4]; s[12] = ev[5];
    return s;
  endfunction

  function automatic logic [15:0] f_read(logic [2:0] a);
    case (a)
      3'd2: return {3'b0, m_mask};
      3'd3: return {3'b0, m_stk};
      3'd4: return f_live(rx_count, tx_count, m_rt, m_tt);
      3'd5: return {9'b0, m_rt};
      3'd6: return {9'b0, m_tt};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check read, clock, update model, check irq
  task automatic step(logic wr, logic [2:0] a, logic [15:0] wd, logic [6:0] rc, logic [6:0] tc,
                      logic [5:0] ev, string tag);
    logic [12:0] clr;
    logic [12:0] nstk, nmask;
    logic [6:0]  nrt, ntt;
    reg_wr = wr; reg_addr = a; reg_wdata = wd; rx_count = rc; tx_count = tc;
    {e_tov, e_mod, e_to, e_par, e_frm, e_ovr} = ev;
    #1;
    if (!wr) check(reg_rdata, f_read(a), tag);
    clr   = (wr && a == 3'd3) ? wd[12:0] : 13'h0;
    nstk  = (m_stk & ~clr) | f_set(f_live(rc, tc, m_rt, m_tt), ev);
    nmask = m_mask;
    if (wr && a == 3'd0) nmask = nmask | wd[12:0];
    if (wr && a == 3'd1) nmask = nmask & ~wd[12:0];
    nrt = (wr && a == 3'd5) ? wd[6:0] : m_rt;
    ntt = (wr && a == 3'd6) ? wd[6:0] : m_tt;
    @(posedge clk);
    #1;
    m_stk = nstk; m_mask = nmask; m_rt = nrt; m_tt = ntt;
    check({15'b0, irq}, {15'b0, |(m_mask & m_stk)}, {tag, " R7 irq"});
    @(negedge clk);
  endtask

  function automatic logic [6:0] pick_cnt(logic [6:0] trig);
    case ($urandom_range(0, 5))
      0: return 7'd0;
      1: return 7'(DEPTH);
      2: return trig;
      3: return (trig == 0) ? 7'd0 : trig - 7'd1;
      default: return 7'($urandom_range(0, DEPTH));
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_mask = '0; m_stk = '0; m_rt = 7'd32; m_tt = 7'd32;
    repeat (3) @(negedge clk);
    // R8 reset state
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      check(reg_rdata, f_read(3'(a)), "R8 reset readback");
    end
    check({15'b0, irq}, 16'h0, "R8 irq in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // counts 0: empty flags (bits 1,3) latched (R3)
    m_stk = f_set(f_live(0, 0, m_rt, m_tt), 6'b0);
    step(0, 3'd3, 0, 0, 0, 0, "R3 empty flags latched");
    check(m_stk, 13'h00A, "R3 model sanity");
    step(0, 3'd2, 0, 0, 0, 0, "R8 mask still zero");
    // R6 enable, write to mask address ignored, disable
    step(1, 3'd2, 16'h1FFF, 5, 5, 0, "R6 direct mask write");
    step(0, 3'd2, 0, 5, 5, 0, "R6 direct write ignored");
    step(1, 3'd0, 16'h0002, 5, 5, 0, "R6 enable bit1");
    check({15'b0, irq}, 16'h1, "R7 irq with mask and sticky");
    // R5 clear loses to a live set: rx_count kept at 0
    step(1, 3'd3, 16'h0002, 0, 5, 0, "R5 clear vs set");
    step(0, 3'd3, 0, 5, 5, 0, "R5 bit1 survives clear");
    step(1, 3'd3, 16'h1FFF, 5, 5, 0, "R5 clear all");
    step(0, 3'd3, 0, 5, 5, 0, "R5 sticky cleared");
    check({15'b0, irq}, 16'h0, "R7 irq low after clear");
    step(1, 3'd1, 16'h0002, 5, 5, 0, "R6 disable bit1");
    step(0, 3'd2, 0, 5, 5, 0, "R6 mask after disable");
    // R2 tx trigger at live bit 13, sticky bit 10
    step(0, 3'd4, 0, 5, 32, 0, "R2 live bit13");
    step(0, 3'd3, 0, 5, 5, 0, "R2 sticky bit10");
    // R1 full flags and rx trigger
    step(0, 3'd4, 0, 64, 64, 0, "R1 full flags");
    step(0, 3'd4, 0, 31, 31, 0, "R1 below trigger");
    // R4 events, each alone, then event vs clear in same cycle
    step(1, 3'd3, 16'h1FFF, 5, 5, 0, "R4 pre-clear");
    for (int i = 0; i < 6; i++)
      step(0, 3'd3, 0, 5, 5, 6'(1 << i), "R4 event bit");
    step(1, 3'd3, 16'h1FFF, 5, 5, 6'b000001, "R5 event beats clear");
    step(0, 3'd3, 0, 5, 5, 0, "R5 overrun kept");
    // R9 trigger registers and ignored live write
    step(1, 3'd5, 16'h0000, 5, 5, 0, "R9 rx trig write");
    step(0, 3'd5, 0, 0, 5, 0, "R9 rx trig read");
    step(0, 3'd4, 0, 0, 5, 0, "R1 trig zero always reached");
    step(1, 3'd6, 16'h0045, 5, 5, 0, "R9 tx trig write");
    step(0, 3'd6, 0, 5, 5, 0, "R9 tx trig read");
    step(1, 3'd4, 16'hFFFF, 5, 5, 0, "R9 live write");
    step(0, 3'd4, 0, 5, 5, 0, "R9 live unchanged");
    step(0, 3'd7, 0, 5, 5, 0, "R9 unused addr");
    step(0, 3'd0, 0, 5, 5, 0, "R9 set port reads zero");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic wr; logic [2:0] a; logic [15:0] wd; logic [5:0] ev;
      wr = ($urandom_range(0, 2) == 0);
      a  = 3'($urandom_range(0, 7));
      wd = (a == 3'd5 || a == 3'd6) ? 16'($urandom_range(0, DEPTH)) : 16'($urandom);
      ev = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'b0;
      step(wr, a, wd, pick_cnt(m_rt), pick_cnt(m_tt), ev, "R1 R3 R4 R5 R6 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule